// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame should be kept, judging only its destination address. A start-of-frame strobe opens a frame. The destination address bytes then follow one per clock while a byte-valid qualifier is high. The first byte on the wire is the first address byte.

Configuration is applied statically:
- a promiscuous enable;
- a broadcast-disable bit;
- a 3-bit address-length field;
- the station's own individual address;
- a 64-bit multicast hash table.

After the last address byte the block pulses a result strobe for one clock. The strobe carries an accept decision and a multicast indication, which the downstream frame pipeline stores into its receive status. Filling the hash table is done elsewhere.

A unicast address is compared exactly against the station address. A group address is checked in one of two ways. The all-ones broadcast address is accepted unless broadcasts are disabled. Any other group address is looked up in the hash table, indexed by the low bits of a CRC-32 taken over the address bytes.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset `resultValid`, `resultAccept` and `resultMcast` are all 0 until a frame completes.
- R2: With `cfgPromisc` = 1 every completed frame gives `resultAccept` = 1. This holds for unicast mismatches, hash misses and disabled broadcasts alike.
- R3: With promiscuous mode off, a unicast address (bit 0 of the first byte is 0) is accepted only when every address byte k equals `stationAddr[8k+7:8k]`. Byte k = 0 is the first byte received.
- R4: The address length L is taken from `cfgAddrLen` in the cycle `sofStrobe` is high, and a code of 7 means L = 0. With L = 0 the result appears in the clock after the strobe, with accept 1 and multicast 0. With L < 6 only the first L bytes are examined.
- R5: A group address whose L bytes are not all 0xFF is accepted when bit `mcastHash[i]` is set. The index i is the low 6 bits of a CRC register computed over the L address bytes in the following way:
  - the register starts at all ones;
  - each byte is processed LSB first;
  - the reflected polynomial 0xEDB88320 is used;
  - no final inversion is applied.
- R6: An address whose L bytes are all 0xFF is accepted without consulting the hash table, unless `cfgBcastDis` = 1. In that case it is rejected, except in promiscuous mode.
- R7: `resultMcast` is 1 exactly when the frame is accepted, L > 0, and bit 0 of the first address byte is 1.
- R8: `resultValid` is a one-clock pulse in the clock after the last address byte is taken. Three kinds of byte are ignored:
  - bytes arriving outside a frame;
  - a byte presented in the same cycle as `sofStrobe`;
  - bytes beyond the L-th.

  A new `sofStrobe` abandons a partly received address and restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sofStrobe | input | 1 | Start of a new frame |
| byteValid | input | 1 | `byteData` carries an address byte |
| byteData | input | 8 | Destination address byte |
| cfgPromisc | input | 1 | Accept every frame |
| cfgBcastDis | input | 1 | Reject the all-ones address |
| cfgAddrLen | input | 3 | Address length in bytes, 7 means 0 |
| stationAddr | input | 48 | Individual address, byte 0 in bits 7:0 |
| mcastHash | input | 64 | Multicast hash table |
| resultValid | output | 1 | Decision strobe |
| resultAccept | output | 1 | Frame accepted (qualified by strobe) |
| resultMcast | output | 1 | Accepted group-addressed frame |

## Verification
For L > 0 the decision is registered once, so `resultValid` and its flags are due one clock after the edge that takes the L-th byte. For L = 0 they are due one clock after the edge that sees `sofStrobe`.

The bench drives inputs on falling edges and samples on the next falling edge after each byte. It expects the strobe on exactly the sample that follows the L-th byte, or the one that follows the start strobe when L is 0. At every other sample it requires the strobe to be low, which catches results that come early, late or twice.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;

  localparam int LEN_W = 3;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic             clear;   // new frame: reset per-frame state
    logic             take;    // consume byteData as an address byte
    logic             finish;  // decision is due this cycle
    logic             empty;   // frame has a zero-length address
    logic [LEN_W-1:0] idx;     // position of the byte being taken
  } filt_strobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rx_dest_filter_ctrl.sv
module rx_dest_filter_ctrl
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sofStrobe,
  input  logic             byteValid,
  input  logic [LEN_W-1:0] cfgAddrLen,
  output filt_strobe_t     stb
);

  localparam logic [LEN_W-1:0] ZERO_CODE = '1;
  localparam logic [LEN_W-1:0] MAX_LEN   = LEN_W'(ADDR_BYTES);

  logic             collecting;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] effLen;
  logic             take;
  logic             lastByte;

  always_comb begin
    effLen = (cfgAddrLen == ZERO_CODE) ? '0 : cfgAddrLen;
    if (effLen > MAX_LEN) effLen = MAX_LEN;
  end

  assign take     = collecting & byteValid & ~sofStrobe;
  assign lastByte = (cnt == lenReg - 1'b1);

  always_comb begin
    stb.clear  = sofStrobe;
    stb.take   = take;
    stb.empty  = sofStrobe && (effLen == '0);
    stb.finish = (sofStrobe && (effLen == '0)) || (take && lastByte);
    stb.idx    = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      collecting <= 1'b0;
      cnt        <= '0;
      lenReg     <= '0;
    end else if (sofStrobe) begin
      collecting <= (effLen != '0);
      cnt        <= '0;
      lenReg     <= effLen;
    end else if (take) begin
      if (lastByte) begin
        collecting <= 1'b0;
        cnt        <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    collecting |-> (cnt < lenReg)); // R4

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (take && lastByte && !sofStrobe) |=> !collecting || $past(sofStrobe)); // R8

endmodule

// File: rtl/rx_dest_filter_dpath.sv
module rx_dest_filter_dpath
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  filt_strobe_t            stb,
  input  logic [7:0]              byteData,
  input  logic                    cfgPromisc,
  input  logic                    cfgBcastDis,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [HASH_BITS-1:0]    mcastHash,
  output logic                    resultValid,
  output logic                    resultAccept,
  output logic                    resultMcast
);

  localparam int HASH_IDX_W = $clog2(HASH_BITS);

  logic [31:0] crcReg, crcBase, crcNext;
  logic        uniMatch, uniBase, uniNext;
  logic        allOnes, onesBase, onesNext;
  logic        groupBit, groupBase, groupNext;
  logic [7:0]  stationByte;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic        hashHit;
  logic        acceptDec;
  logic        mcastDec;

  always_comb begin
    stationByte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (stb.idx == LEN_W'(i)) stationByte = stationAddr[8*i +: 8];
    end
  end

  always_comb begin
    crcBase   = stb.clear ? '1   : crcReg;
    uniBase   = stb.clear ? 1'b1 : uniMatch;
    onesBase  = stb.clear ? 1'b1 : allOnes;
    groupBase = stb.clear ? 1'b0 : groupBit;
    if (stb.take) begin
      crcNext   = crcStep(crcBase, byteData);
      uniNext   = uniBase  & (byteData == stationByte);
      onesNext  = onesBase & (byteData == 8'hFF);
      groupNext = (stb.idx == '0) ? byteData[0] : groupBase;
    end else begin
      crcNext   = crcBase;
      uniNext   = uniBase;
      onesNext  = onesBase;
      groupNext = groupBase;
    end
  end

  assign hashIdx = crcNext[HASH_IDX_W-1:0];
  assign hashHit = mcastHash[hashIdx];

  always_comb begin
    if (stb.empty)       acceptDec = 1'b1;
    else if (cfgPromisc) acceptDec = 1'b1;
    else if (groupNext)  acceptDec = onesNext ? !cfgBcastDis : hashHit;
    else                 acceptDec = uniNext;
    mcastDec = acceptDec & groupNext & !stb.empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg       <= '1;
      uniMatch     <= 1'b1;
      allOnes      <= 1'b1;
      groupBit     <= 1'b0;
      resultValid  <= 1'b0;
      resultAccept <= 1'b0;
      resultMcast  <= 1'b0;
    end else begin
      crcReg       <= crcNext;
      uniMatch     <= uniNext;
      allOnes      <= onesNext;
      groupBit     <= groupNext;
      resultValid  <= stb.finish;
      resultAccept <= stb.finish & acceptDec;
      resultMcast  <= stb.finish & mcastDec;
    end
  end

  AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && cfgPromisc) |=> (resultValid && resultAccept)); // R2

  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && stb.empty) |=> (resultAccept && !resultMcast)); // R4

  AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !stb.empty && !cfgPromisc && cfgBcastDis && onesNext)
      |=> (resultValid && !resultAccept)); // R6

  AST_MCAST_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    resultMcast |-> (resultAccept && resultValid)); // R7

  AST_RESULT_FOLLOWS_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(stb.finish)); // R8

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sofStrobe,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  input  logic                    cfgPromisc,
  input  logic                    cfgBcastDis,
  input  logic [LEN_W-1:0]        cfgAddrLen,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [HASH_BITS-1:0]    mcastHash,
  output logic                    resultValid,
  output logic                    resultAccept,
  output logic                    resultMcast
);

  filt_strobe_t stb;

  rx_dest_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sofStrobe  (sofStrobe),
    .byteValid  (byteValid),
    .cfgAddrLen (cfgAddrLen),
    .stb        (stb)
  );

  rx_dest_filter_dpath #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .byteData     (byteData),
    .cfgPromisc   (cfgPromisc),
    .cfgBcastDis  (cfgBcastDis),
    .stationAddr  (stationAddr),
    .mcastHash    (mcastHash),
    .resultValid  (resultValid),
    .resultAccept (resultAccept),
    .resultMcast  (resultMcast)
  );

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rstN |=> !resultValid); // R1

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sofStrobe;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        cfgPromisc;
  logic        cfgBcastDis;
  logic [2:0]  cfgAddrLen;
  logic [47:0] stationAddr;
  logic [63:0] mcastHash;
  logic        resultValid;
  logic        resultAccept;
  logic        resultMcast;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  localparam logic [47:0] STATION = 48'h6a5b4c3d2e1a;
  localparam logic [47:0] MC_ADDR = 48'h3322115e0001;
  localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;

  always #10 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .byteValid(byteValid),
    .byteData(byteData), .cfgPromisc(cfgPromisc), .cfgBcastDis(cfgBcastDis),
    .cfgAddrLen(cfgAddrLen), .stationAddr(stationAddr), .mcastHash(mcastHash),
    .resultValid(resultValid), .resultAccept(resultAccept), .resultMcast(resultMcast)
  );

  function automatic logic [31:0] refCrc(input logic [47:0] a, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ a[8*i+b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Drives one frame and checks the strobe position and decision.
  task automatic runFrame(input string req, input logic [47:0] addr, input int nSend,
                          input bit expAcc, input bit expMc, input bit junkOnSof);
    int effL;
    effL = (cfgAddrLen == 3'd7) ? 0 : int'(cfgAddrLen);
    @(negedge clk);
    sofStrobe = 1'b1;
    byteValid = junkOnSof;
    byteData  = ~addr[7:0];
    @(negedge clk);
    sofStrobe = 1'b0;
    byteValid = 1'b0;
    if (effL == 0) begin
      check(resultValid === 1'b1, req, "valid after empty sof", 32'(resultValid), 1);
      check(resultAccept === expAcc, req, "accept", 32'(resultAccept), 32'(expAcc));
      check(resultMcast === expMc, req, "mcast", 32'(resultMcast), 32'(expMc));
    end
    for (int k = 0; k < nSend; k++) begin
      byteValid = 1'b1;
      byteData  = addr[8*k +: 8];
      @(negedge clk);
      if (k == effL - 1) begin
        check(resultValid === 1'b1, req, "valid after last byte", 32'(resultValid), 1);
        check(resultAccept === expAcc, req, "accept", 32'(resultAccept), 32'(expAcc));
        check(resultMcast === expMc, req, "mcast", 32'(resultMcast), 32'(expMc));
      end else begin
        check(resultValid === 1'b0, "R8", "no strobe mid/after frame", 32'(resultValid), 0);
      end
    end
    byteValid = 1'b0;
  endtask

  task automatic setCfg(input bit p, input bit bd, input logic [2:0] len, input logic [63:0] h);
    cfgPromisc = p; cfgBcastDis = bd; cfgAddrLen = len; mcastHash = h;
  endtask

  task automatic testReset();
    check(resultValid === 1'b0 && resultAccept === 1'b0 && resultMcast === 1'b0,
          "R1", "outputs after reset", {29'd0, resultValid, resultAccept, resultMcast}, 0);
  endtask

  task automatic testUnicast();
    setCfg(0, 0, 3'd6, '0);
    runFrame("R3", STATION, 6, 1, 0, 0);
    runFrame("R3", STATION ^ 48'h800000000000, 6, 0, 0, 0);
    runFrame("R3", STATION ^ 48'h000000000100, 6, 0, 0, 0);
  endtask

  task automatic testShortLen();
    setCfg(0, 0, 3'd2, '0);
    // later bytes differ from the station but are beyond L; extra bytes ignored (R8)
    runFrame("R4", {~STATION[47:16], STATION[15:0]}, 6, 1, 0, 0);
    setCfg(0, 0, 3'd7, '0);
    runFrame("R4", 48'h010203040506, 3, 1, 0, 0);
    setCfg(0, 0, 3'd0, '0);
    runFrame("R4", BCAST, 0, 1, 0, 0);
  endtask

  task automatic testHash();
    logic [5:0] idx;
    idx = refCrc(MC_ADDR, 6)[5:0];
    setCfg(0, 0, 3'd6, 64'd1 << idx);
    runFrame("R5", MC_ADDR, 6, 1, 1, 0);
    setCfg(0, 0, 3'd6, ~(64'd1 << idx));
    runFrame("R5", MC_ADDR, 6, 0, 0, 0);
    idx = refCrc(MC_ADDR, 3)[5:0];
    setCfg(0, 0, 3'd3, 64'd1 << idx);
    runFrame("R5", MC_ADDR, 3, 1, 1, 0);
  endtask

  task automatic testBroadcast();
    setCfg(0, 0, 3'd6, '0);
    runFrame("R6", BCAST, 6, 1, 1, 0);
    setCfg(0, 1, 3'd6, '1);
    runFrame("R6", BCAST, 6, 0, 0, 0);
  endtask

  task automatic testPromisc();
    setCfg(1, 1, 3'd6, '0);
    runFrame("R2", BCAST, 6, 1, 1, 0);
    runFrame("R2", STATION ^ 48'h000000FF0000, 6, 1, 0, 0);
    runFrame("R7", MC_ADDR, 6, 1, 1, 0);
  endtask

  task automatic testIgnoredBytes();
    setCfg(0, 0, 3'd6, '0);
    @(negedge clk);
    byteValid = 1'b1; byteData = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      check(resultValid === 1'b0, "R8", "idle bytes ignored", 32'(resultValid), 0);
    end
    byteValid = 1'b0;
    runFrame("R8", STATION, 6, 1, 0, 1);
  endtask

  task automatic testRestart();
    setCfg(0, 0, 3'd6, '0);
    @(negedge clk);
    sofStrobe = 1'b1;
    @(negedge clk);
    sofStrobe = 1'b0; byteValid = 1'b1; byteData = 8'h55;
    @(negedge clk);
    byteData = 8'h66;
    @(negedge clk);
    byteValid = 1'b0;
    check(resultValid === 1'b0, "R8", "partial frame gives no strobe", 32'(resultValid), 0);
    runFrame("R8", STATION, 6, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sofStrobe = 1'b0; byteValid = 1'b0; byteData = '0;
    stationAddr = STATION;
    setCfg(0, 0, 3'd6, '0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnicast();
    testShortLen();
    testHash();
    testBroadcast();
    testPromisc();
    testIgnoredBytes();
    testRestart();
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule